// File: doc/BRIEF.md
# Auto-reload event timer

This block is a memory-mapped timer that counts up. A prescaler divides the clock, and each prescaled tick advances a counter. When the counter reaches the active reload limit it wraps to zero and raises an update event. The update sets a flag. When the matching enable bit is set, that flag drives a level interrupt.

The timer has two uses. In periodic mode it reloads forever and so serves as a tick source. In one-shot mode it fires once and then stops itself, so it can time a single deadline. Software can force an update at any time. A forced update restarts both counting stages and commits a newly written prescale ratio. The counter width is a build parameter, 16 or 32 bits. Software can find the width by writing all ones to the reload register and reading it back.

The bus is a single-cycle register port with address, write data and write strobe. Read data is registered and appears one clock after the address.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset, `irq` is 0. Every register at 0x00, 0x0C, 0x10, 0x28 and 0x2C reads 0.
- R2: Read data appears on the clock after the address. Control (0x00) stores and returns only bit 0 (run), bit 3 (once) and bit 7 (reload buffering); its other bits read 0. Interrupt enable (0x0C) keeps only bit 0. Prescale (0x28) keeps its low PSC_W bits. The event register (0x14) reads 0.
- R3: The reload register (0x2C) keeps only its low CNT_W bits. With CNT_W=16, writing 0xFFFFFFFF reads back 0x0000FFFF.
- R4: A prescale value P and a reload limit A are loaded into the active stages. After counting is enabled from a restarted state, the first update comes (P+1)*(A+1) clocks after the enabling write. While run is 0 the counter holds.
- R5: A write to the prescale register does not change the active ratio. The new ratio takes effect only at the next update event, whether natural or forced.
- R6: With once (bit 3) set, an update clears run (bit 0) and leaves the other control bits unchanged. No further update follows until run is set again.
- R7: With once clear, the timer produces an update every (P+1)*(A+1) clocks. Writing 0 to control stops it.
- R8: With reload buffering (bit 7) set, a reload write is used only after the next update. With buffering clear, the new limit applies at once.
- R9: Writing 1 to bit 0 of the event register forces an update. The forced update sets the flag (status bit 0), loads the prescale value, and restarts the prescaler and the counter from 0. The next natural update then comes (P+1)*(A+1) clocks later.
- R10: Writing 0 to status bit 0 clears the flag. Writing 1 leaves the flag unchanged in either state.
- R11: `irq` equals the flag AND interrupt enable bit 0, on the same cycle.
- R12: If an update event and a flag-clearing write happen on the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| irq | output | 1 | Level interrupt: update flag AND its enable |

## Verification
Two functions can fall on the same clock: the hardware update that sets the flag, and a software write that clears it. The bench first provokes this. It runs the timer periodically with a known period, clears the flag early, and then times a second clearing write so that it commits on exactly the edge where the next update is due. The check passes only if the flag reads back as set and the interrupt rise lands on that same edge. A second overlap is the one-shot stop against a control write; the checker covers the case where no control write is present.

// File: rtl/et_pkg.sv
package et_pkg;
  localparam int OFS_CTL = 'h00;
  localparam int OFS_IEN = 'h0C;
  localparam int OFS_STS = 'h10;
  localparam int OFS_EVG = 'h14;
  localparam int OFS_PSC = 'h28;
  localparam int OFS_ARR = 'h2C;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_ONCE_BIT = 3;
  localparam int CTL_BUF_BIT  = 7;
  localparam int IEN_UPD_BIT  = 0;
  localparam int STS_UPD_BIT  = 0;
  localparam int EVG_UPD_BIT  = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_IEN,
    SEL_STS,
    SEL_EVG,
    SEL_PSC,
    SEL_ARR
  } reg_sel_e;
endpackage

// File: rtl/et_regs.sv
module et_regs
  import et_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              hw_upd,
  output logic              run,
  output logic              once,
  output logic              preload,
  output logic [PSC_W-1:0]  psc_pend,
  output logic [CNT_W-1:0]  arr_pre,
  output logic              force_upd,
  output logic              flag,
  output logic              ien,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  reg_sel_e    sel;
  logic        wr_ctl, wr_ien, wr_sts, wr_psc, wr_arr;
  logic        flag_n, ien_n;
  logic [DATA_W-1:0] rd_mux;
  logic        unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_CTL): sel = SEL_CTL;
      ADDR_W'(OFS_IEN): sel = SEL_IEN;
      ADDR_W'(OFS_STS): sel = SEL_STS;
      ADDR_W'(OFS_EVG): sel = SEL_EVG;
      ADDR_W'(OFS_PSC): sel = SEL_PSC;
      ADDR_W'(OFS_ARR): sel = SEL_ARR;
      default:          sel = SEL_NONE;
    endcase
  end

  assign wr_ctl    = bus_we && (sel == SEL_CTL);
  assign wr_ien    = bus_we && (sel == SEL_IEN);
  assign wr_sts    = bus_we && (sel == SEL_STS);
  assign wr_psc    = bus_we && (sel == SEL_PSC);
  assign wr_arr    = bus_we && (sel == SEL_ARR);
  assign force_upd = bus_we && (sel == SEL_EVG) && bus_wdata[EVG_UPD_BIT];

  // hardware set has priority over a software clear in the same cycle
  always_comb begin
    flag_n = flag;
    if (wr_sts && !bus_wdata[STS_UPD_BIT]) flag_n = 1'b0;
    if (hw_upd || force_upd)               flag_n = 1'b1;
  end

  assign ien_n = wr_ien ? bus_wdata[IEN_UPD_BIT] : ien;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTL: begin
        rd_mux[CTL_RUN_BIT]  = run;
        rd_mux[CTL_ONCE_BIT] = once;
        rd_mux[CTL_BUF_BIT]  = preload;
      end
      SEL_IEN: rd_mux[IEN_UPD_BIT] = ien;
      SEL_STS: rd_mux[STS_UPD_BIT] = flag;
      SEL_PSC: rd_mux[PSC_W-1:0]   = psc_pend;
      SEL_ARR: rd_mux[CNT_W-1:0]   = arr_pre;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      once      <= 1'b0;
      preload   <= 1'b0;
      flag      <= 1'b0;
      ien       <= 1'b0;
      irq       <= 1'b0;
      psc_pend  <= '0;
      arr_pre   <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctl) begin
        run     <= bus_wdata[CTL_RUN_BIT];
        once    <= bus_wdata[CTL_ONCE_BIT];
        preload <= bus_wdata[CTL_BUF_BIT];
      end else if (hw_upd && once) begin
        run <= 1'b0;
      end
      if (wr_psc) psc_pend <= bus_wdata[PSC_W-1:0];
      if (wr_arr) arr_pre  <= bus_wdata[CNT_W-1:0];
      flag      <= flag_n;
      ien       <= ien_n;
      irq       <= flag_n & ien_n;
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/et_presc.sv
module et_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             reload,
  input  logic [PSC_W-1:0] psc_pend,
  output logic             tick
);
  logic [PSC_W-1:0] div_act;
  logic [PSC_W-1:0] div_cnt;
  logic             wrap;

  assign wrap = (div_cnt == div_act);
  assign tick = run && wrap && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_act <= '0;
      div_cnt <= '0;
    end else begin
      if (restart)  div_cnt <= '0;
      else if (run) div_cnt <= wrap ? '0 : div_cnt + 1'b1;
      if (restart || reload) div_act <= psc_pend;
    end
  end
endmodule

// File: rtl/et_count.sv
module et_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             preload,
  input  logic [CNT_W-1:0] arr_pre,
  output logic             hw_upd,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] arr_sh;
  logic [CNT_W-1:0] arr_use;

  assign arr_use = preload ? arr_sh : arr_pre;
  assign hw_upd  = tick && (count == arr_use);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      arr_sh <= '0;
    end else begin
      if (restart)   count <= '0;
      else if (tick) count <= hw_upd ? '0 : count + 1'b1;
      if (restart || hw_upd) arr_sh <= arr_pre;
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             run, once, preload, flag, ien;
  logic             force_upd, hw_upd, tick;
  logic [PSC_W-1:0] psc_pend;
  logic [CNT_W-1:0] arr_pre;
  logic [CNT_W-1:0] count;

  et_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .hw_upd(hw_upd),
    .run(run), .once(once), .preload(preload),
    .psc_pend(psc_pend), .arr_pre(arr_pre),
    .force_upd(force_upd), .flag(flag), .ien(ien),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  et_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst(rst),
    .run(run), .restart(force_upd), .reload(hw_upd),
    .psc_pend(psc_pend), .tick(tick)
  );

  et_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst),
    .tick(tick), .restart(force_upd), .preload(preload),
    .arr_pre(arr_pre), .hw_upd(hw_upd), .count(count)
  );
endmodule

// File: rtl/et_chk.sv
module et_chk
  import et_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              wbit0,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              run,
  input logic              once,
  input logic              flag,
  input logic              ien,
  input logic              hw_upd,
  input logic              force_upd,
  input logic [CNT_W-1:0]  count
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_ARR = ADDR_W'(OFS_ARR);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'({CNT_W{1'b1}});

  logic rd_was_arr;
  always_ff @(posedge clk) begin
    if (rst) rd_was_arr <= 1'b0;
    else     rd_was_arr <= (bus_addr == A_ARR);
  end

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ien));

  p_upd_sets_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (hw_upd || force_upd) |=> flag);

  p_clear_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_STS && !wbit0 && !hw_upd && !force_upd) |=> !flag);

  p_once_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (hw_upd && once && !(bus_we && bus_addr == A_CTL)) |=> !run);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !force_upd) |=> $stable(count));

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    hw_upd |=> (count == '0));

  p_arr_trunc_r3: assert property (@(posedge clk) disable iff (rst)
    rd_was_arr |-> ((bus_rdata & ~LOW_MASK) == '0));
endmodule

bind evt_timer et_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst),
  .bus_addr(bus_addr), .bus_we(bus_we), .wbit0(bus_wdata[0]),
  .bus_rdata(bus_rdata), .irq(irq),
  .run(run), .once(once), .flag(flag), .ien(ien),
  .hw_upd(hw_upd), .force_upd(force_upd), .count(count)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int PSC_W  = 16;
  localparam logic [7:0] CTL = 8'h00, IEN = 8'h0C, STS = 8'h10,
                         EVG = 8'h14, PSC = 8'h28, ARR = 8'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  wire  [DATA_W-1:0] bus_rdata;
  wire  irq;

  always #2 clk = ~clk;

  evt_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int rise_cnt = 0, rise_cyc = 0;
  int last_wr = 0;
  bit irq_prev = 1'b0;
  bit rd_issue = 1'b0;
  bit done = 1'b0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: interrupt rise stamps and read scoreboard, sampled 1 ns after the edge
  always begin
    @(posedge clk);
    #1;
    if (!rst && irq && !irq_prev) begin
      rise_cnt++;
      rise_cyc = cyc;
    end
    irq_prev = irq;
    if (rd_issue) begin
      if (q_exp.size() == 0) chk("R2", "unexpected read", 1, 0);
      else chk(q_tag.pop_front(), "read data", bus_rdata, q_exp.pop_front());
    end
  end

  task automatic wr_now(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    last_wr = cyc;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    q_exp.push_back(exp);
    q_tag.push_back(req);
    rd_issue = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic wait_rise(input string req, input int limit);
    int start = rise_cnt;
    int k = 0;
    while (rise_cnt == start && k < limit) begin
      @(negedge clk);
      k++;
    end
    if (rise_cnt == start) chk(req, "update not seen", 0, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int r0, r1, ef;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1", "irq after reset", irq, 0);
    rd(CTL, 0, "R1"); rd(IEN, 0, "R1"); rd(STS, 0, "R1");
    rd(PSC, 0, "R1"); rd(ARR, 0, "R1");

    // R2 field widths and readback
    wr(CTL, 32'h0000_0088); rd(CTL, 32'h88, "R2");
    wr(CTL, 32'hFFFF_FF76); rd(CTL, 32'h0, "R2");
    wr(IEN, 32'hFFFF_FFFF); rd(IEN, 32'h1, "R2");
    wr(IEN, 32'h0);
    wr(PSC, 32'hFFFF_FFFF); rd(PSC, 32'h0000_FFFF, "R2");
    wr(PSC, 32'h0);
    rd(EVG, 32'h0, "R2");

    // R3 width discovery through reload readback
    wr(ARR, 32'hFFFF_FFFF); rd(ARR, 32'h0000_FFFF, "R3");

    // R9 R10 R11 forced update, flag clear rules, interrupt gating
    wr(EVG, 32'h1);
    chk("R11", "irq with enable off", irq, 0);
    rd(STS, 1, "R9");
    wr(STS, 32'h1); rd(STS, 1, "R10");
    wr(IEN, 32'h1);
    chk("R11", "irq after enable", irq, 1);
    wr(STS, 32'h0);
    chk("R11", "irq after clear", irq, 0);
    rd(STS, 0, "R10");
    wr(STS, 32'h1); rd(STS, 0, "R10");

    // R4 one-shot timing P=2 A=3 -> 12 clocks
    wr(ARR, 3); wr(PSC, 2); wr(EVG, 1); wr(STS, 0);
    wr(CTL, 32'h09); r0 = last_wr;
    wait_rise("R4", 100);
    chk("R4", "first update delay", rise_cyc - r0, 12);
    // R6 one-shot stops itself
    rd(CTL, 32'h08, "R6");
    wr(STS, 0); r1 = rise_cnt;
    idle(40);
    chk("R6", "no update after stop", rise_cnt, r1);
    rd(STS, 0, "R6");

    // R5 pending prescale waits for an update
    wr(PSC, 0); wr(STS, 0);
    wr(CTL, 32'h09); r0 = last_wr;
    wait_rise("R5", 100);
    chk("R5", "old ratio still active", rise_cyc - r0, 12);
    wr(STS, 0);
    wr(CTL, 32'h09); r0 = last_wr;
    wait_rise("R5", 100);
    chk("R5", "new ratio after update", rise_cyc - r0, 4);

    // R7 periodic P=1 A=4 -> 10 clocks
    wr(PSC, 1); wr(ARR, 4); wr(EVG, 1); wr(STS, 0);
    wr(CTL, 32'h01); r0 = last_wr;
    wait_rise("R7", 100);
    chk("R7", "first period", rise_cyc - r0, 10);
    r1 = rise_cyc;
    wr(STS, 0);
    wait_rise("R7", 100);
    chk("R7", "repeat period", rise_cyc - r1, 10);
    rd(CTL, 32'h01, "R7");
    wr(CTL, 0); wr(STS, 0); r1 = rise_cnt;
    idle(30);
    chk("R7", "stopped by control write", rise_cnt, r1);

    // R8 buffered reload
    wr(PSC, 0); wr(CTL, 32'h80); wr(ARR, 7); wr(EVG, 1); wr(STS, 0);
    wr(ARR, 3);
    wr(CTL, 32'h81); r0 = last_wr;
    wait_rise("R8", 100);
    chk("R8", "buffered: old limit", rise_cyc - r0, 8);
    r1 = rise_cyc;
    wr(STS, 0);
    wait_rise("R8", 100);
    chk("R8", "buffered: new limit", rise_cyc - r1, 4);
    wr(CTL, 0);
    wr(EVG, 1); wr(STS, 0); wr(ARR, 5);
    wr(CTL, 32'h01); r0 = last_wr;
    wait_rise("R8", 100);
    chk("R8", "unbuffered: immediate limit", rise_cyc - r0, 6);
    wr(CTL, 0);

    // R9 forced update restarts a running count, P=0 A=9
    wr(ARR, 9); wr(EVG, 1); wr(STS, 0);
    wr(CTL, 32'h01);
    wait_rise("R9", 100);
    wr(STS, 0);
    wr(EVG, 1); ef = last_wr;
    chk("R9", "forced update sets flag", rise_cyc, ef);
    wr(STS, 0);
    wait_rise("R9", 100);
    chk("R9", "restart to next update", rise_cyc - ef, 10);

    // R12 clear write on the update edge
    r1 = rise_cyc;
    wr(STS, 0);
    while (cyc != r1 + 9) @(negedge clk);
    wr_now(STS, 0);
    chk("R12", "update edge", rise_cyc, r1 + 10);
    rd(STS, 1, "R12");
    wr(CTL, 0);

    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule